// File: doc/BRIEF.md
# Four-Digit Decimal Arithmetic Unit

This is a purely combinational unit for a decimal register machine. Every word in that machine is four BCD digits, so the unit works on digits and never on binary values. It takes a destination operand `opA` (d), a source operand `opB` (s), a 3-bit operation select and a 3-bit condition select. It returns a BCD result, which the surrounding core writes back into d. Alongside the result it returns zero, negative, overflow and invalid-digit flags, plus one condition bit that compares `opA` against zero.

Signed values are held in ten's complement across the four digits. A leading digit of 0 to 4 means the word is zero or positive. A leading digit of 5 to 9 means it is negative, so the signed range is -5000 to 4999. Additions carry from digit to digit in decimal. Subtraction adds the nine's complement of the subtrahend with a carry-in of one. The two shifts move whole digits, which multiplies or divides the word by ten.

Inside the unit, a decoder turns the operation select into a small set of strobes. These strobes steer a digit-serial adder, a digit shifter and a flag stage.

Top module: `dec4_alu`

## Requirements
- R1: With `opSel`=0 (clear), `result` is 0000 and `zeroFlag` is 1, whatever the operands, and `badDigit` is 0.
- R2: With `opSel`=1 (increment) `result` is (A+1) mod 10000; with `opSel`=2 (decrement) it is (A-1) mod 10000, so 9999+1 gives 0000 and 0000-1 gives 9999.
- R3: With `opSel`=3 (negate) `result` is (0-A) mod 10000, so 0000 stays 0000 and 5000 stays 5000.
- R4: With `opSel`=4 (shift left) `result` is (A*10) mod 10000: each digit moves up one place, the top digit is lost and the lowest digit becomes 0.
- R5: With `opSel`=5 (shift right) `result` is A/10 rounded down on the unsigned value: the lowest digit is lost and the top digit becomes 0, even for a negative A.
- R6: With `opSel`=6 (add) `result` is (A+B) mod 10000, with decimal carries between digits.
- R7: With `opSel`=7 (subtract) `result` is (A-B) mod 10000.
- R8: `ovfFlag` is 1 only for add or subtract, and only when the exact signed sum or difference lies outside -5000..4999. It is 0 for every other operation.
- R9: `negFlag` is 1 exactly when the top digit of `result` is 5 to 9, and `zeroFlag` is 1 exactly when `result` is 0000.
- R10: `condMet` tests the signed value of `opA` against zero. The `condSel` values are 0 equal, 1 not equal, 2 greater, 3 greater or equal, 4 less, 5 less or equal, 6 always true and 7 never. The bit is 0 whenever `opA` holds a digit above 9.
- R11: An operand digit above 9 sets `badDigit`, forces `result` to 0000 and clears `ovfFlag`. `opA` is checked for every operation except clear, and `opB` only for add and subtract.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | 16 | Destination operand d, four BCD digits |
| opB | input | 16 | Source operand s, four BCD digits |
| opSel | input | 3 | Operation: 0 clear, 1 inc, 2 dec, 3 negate, 4 shift left, 5 shift right, 6 add, 7 subtract |
| condSel | input | 3 | Comparison of opA against zero (encoding in R10) |
| result | output | 16 | BCD result |
| zeroFlag | output | 1 | Result equals 0000 |
| negFlag | output | 1 | Result top digit is 5 to 9 |
| ovfFlag | output | 1 | Signed overflow on add or subtract |
| badDigit | output | 1 | An operand that is used holds a non-decimal digit |
| condMet | output | 1 | Selected comparison of opA holds |

## Verification
The adder is tried with operands that carry through no digits, through one digit, and through all four digits. This separates a broken per-digit decimal correction from a broken carry chain. Add and subtract are run at and just past the signed boundaries 4999, 5000 and 9999, which tells a correct overflow rule from one that only looks at the carry out. The shifts use a negative operand, which shows a logical digit shift and not a sign fill. The comparisons are swept over 0000, 0001, 4999, 5000 and 9999, so that each condition is separated from its neighbour.

// File: rtl/dec4_pkg.sv
package dec4_pkg;

  typedef enum logic [2:0] {
    OP_CLR = 3'd0, OP_INC = 3'd1, OP_DEC = 3'd2, OP_NEG = 3'd3,
    OP_SHL = 3'd4, OP_SHR = 3'd5, OP_ADD = 3'd6, OP_SUB = 3'd7
  } opSel_e;

  typedef enum logic [2:0] {
    CND_EQ = 3'd0, CND_NE = 3'd1, CND_GT = 3'd2, CND_GE = 3'd3,
    CND_LT = 3'd4, CND_LE = 3'd5, CND_ALWAYS = 3'd6, CND_NEVER = 3'd7
  } cond_e;

  typedef enum logic [2:0] {
    Y_ZERO, Y_OPB, Y_NINE_A, Y_NINE_B, Y_ALL_NINE
  } ySel_e;

  typedef enum logic [1:0] {
    R_SUM, R_SHL, R_SHR, R_ZERO
  } resSel_e;

  typedef struct packed {
    logic    xZero;
    ySel_e   ySel;
    logic    carryIn;
    resSel_e resSel;
    logic    chkA;
    logic    chkB;
    logic    ovfEn;
  } strobes_t;

endpackage

// File: rtl/dec4_ctrl.sv
module dec4_ctrl
  import dec4_pkg::*;
(
  input  logic [2:0] opSel,
  output strobes_t   stb
);

  always_comb begin
    stb = '{xZero: 1'b0, ySel: Y_ZERO, carryIn: 1'b0, resSel: R_SUM,
            chkA: 1'b1, chkB: 1'b0, ovfEn: 1'b0};
    case (opSel_e'(opSel))
      OP_CLR: begin
        stb.resSel = R_ZERO;
        stb.chkA   = 1'b0;
      end
      OP_INC: stb.carryIn = 1'b1;
      OP_DEC: stb.ySel = Y_ALL_NINE;
      OP_NEG: begin
        stb.xZero   = 1'b1;
        stb.ySel    = Y_NINE_A;
        stb.carryIn = 1'b1;
      end
      OP_SHL: stb.resSel = R_SHL;
      OP_SHR: stb.resSel = R_SHR;
      OP_ADD: begin
        stb.ySel  = Y_OPB;
        stb.chkB  = 1'b1;
        stb.ovfEn = 1'b1;
      end
      OP_SUB: begin
        stb.ySel    = Y_NINE_B;
        stb.carryIn = 1'b1;
        stb.chkB    = 1'b1;
        stb.ovfEn   = 1'b1;
      end
      default: stb.resSel = R_ZERO;
    endcase
  end

endmodule

// File: rtl/dec4_dp.sv
module dec4_dp
  import dec4_pkg::*;
#(
  parameter int DIGITS = 4
) (
  input  logic [4*DIGITS-1:0] opA,
  input  logic [4*DIGITS-1:0] opB,
  input  logic [2:0]          condSel,
  input  strobes_t            stb,
  output logic [4*DIGITS-1:0] result,
  output logic                zeroFlag,
  output logic                negFlag,
  output logic                ovfFlag,
  output logic                badDigit,
  output logic                condMet
);

  localparam int W = 4 * DIGITS;

  logic [DIGITS-1:0] aDigOk, bDigOk;
  logic [W-1:0]      ninesA, ninesB, xOp, yOp, sumW, resPre;
  logic [DIGITS:0]   cy;

  for (genvar i = 0; i < DIGITS; i++) begin : g_digit
    logic [4:0] raw;
    logic       big;
    assign aDigOk[i]      = opA[4*i +: 4] < 4'd10;
    assign bDigOk[i]      = opB[4*i +: 4] < 4'd10;
    assign ninesA[4*i +: 4] = 4'd9 - opA[4*i +: 4];
    assign ninesB[4*i +: 4] = 4'd9 - opB[4*i +: 4];
    assign raw            = {1'b0, xOp[4*i +: 4]} + {1'b0, yOp[4*i +: 4]} + {4'b0, cy[i]};
    assign big            = raw > 5'd9;
    assign sumW[4*i +: 4] = big ? (raw[3:0] + 4'd6) : raw[3:0];
    assign cy[i+1]        = big;
  end

  assign cy[0] = stb.carryIn;
  assign xOp   = stb.xZero ? '0 : opA;

  always_comb begin
    case (stb.ySel)
      Y_OPB:      yOp = opB;
      Y_NINE_A:   yOp = ninesA;
      Y_NINE_B:   yOp = ninesB;
      Y_ALL_NINE: yOp = {DIGITS{4'd9}};
      default:    yOp = '0;
    endcase
  end

  always_comb begin
    case (stb.resSel)
      R_SUM:   resPre = sumW;
      R_SHL:   resPre = {opA[W-5:0], 4'd0};
      R_SHR:   resPre = {4'd0, opA[W-1:4]};
      default: resPre = '0;
    endcase
  end

  logic negX, negY, negS, aNeg, aZero, aHit;
  assign negX = xOp[W-1 -: 4] >= 4'd5;
  assign negY = yOp[W-1 -: 4] >= 4'd5;
  assign negS = sumW[W-1 -: 4] >= 4'd5;

  assign badDigit = (stb.chkA & ~&aDigOk) | (stb.chkB & ~&bDigOk);
  assign result   = badDigit ? '0 : resPre;
  assign ovfFlag  = stb.ovfEn & ~badDigit & (negX == negY) & (negS != negX);
  assign zeroFlag = result == '0;
  assign negFlag  = result[W-1 -: 4] >= 4'd5;

  assign aNeg  = opA[W-1 -: 4] >= 4'd5;
  assign aZero = opA == '0;

  always_comb begin
    case (cond_e'(condSel))
      CND_EQ:     aHit = aZero;
      CND_NE:     aHit = ~aZero;
      CND_GT:     aHit = ~aZero & ~aNeg;
      CND_GE:     aHit = ~aNeg;
      CND_LT:     aHit = aNeg;
      CND_LE:     aHit = aNeg | aZero;
      CND_ALWAYS: aHit = 1'b1;
      default:    aHit = 1'b0;
    endcase
  end

  assign condMet = aHit & (&aDigOk);

endmodule

// File: rtl/dec4_alu.sv
module dec4_alu
  import dec4_pkg::*;
#(
  parameter int DIGITS = 4
) (
  input  logic [4*DIGITS-1:0] opA,
  input  logic [4*DIGITS-1:0] opB,
  input  logic [2:0]          opSel,
  input  logic [2:0]          condSel,
  output logic [4*DIGITS-1:0] result,
  output logic                zeroFlag,
  output logic                negFlag,
  output logic                ovfFlag,
  output logic                badDigit,
  output logic                condMet
);

  strobes_t stb;

  dec4_ctrl i_ctrl (
    .opSel (opSel),
    .stb   (stb)
  );

  dec4_dp #(.DIGITS(DIGITS)) i_dp (
    .opA      (opA),
    .opB      (opB),
    .condSel  (condSel),
    .stb      (stb),
    .result   (result),
    .zeroFlag (zeroFlag),
    .negFlag  (negFlag),
    .ovfFlag  (ovfFlag),
    .badDigit (badDigit),
    .condMet  (condMet)
  );

endmodule

// File: rtl/dec4_alu_chk.sv
module dec4_alu_chk
  import dec4_pkg::*;
#(
  parameter int DIGITS = 4
) (
  input logic [4*DIGITS-1:0] opA,
  input logic [2:0]          opSel,
  input logic [4*DIGITS-1:0] result,
  input logic                zeroFlag,
  input logic                negFlag,
  input logic                ovfFlag,
  input logic                badDigit
);

  localparam int W = 4 * DIGITS;

  always_comb begin
    if (!$isunknown({opA, opSel, result, zeroFlag, negFlag, ovfFlag, badDigit})) begin
      AST_CLEAR_ZERO: assert (opSel != OP_CLR || (result == '0 && zeroFlag && !badDigit)); // R1
      AST_SHL_LOW_ZERO: assert (opSel != OP_SHL || result[3:0] == 4'd0); // R4
      AST_SHR_TOP_ZERO: assert (opSel != OP_SHR || result[W-1 -: 4] == 4'd0); // R5
      AST_OVF_ARITH_ONLY: assert (!ovfFlag || opSel == OP_ADD || opSel == OP_SUB); // R8
      AST_ZERO_NOT_NEG: assert (!(zeroFlag && negFlag)); // R9
      AST_BAD_FORCES_ZERO: assert (!badDigit || (result == '0 && !ovfFlag)); // R11
    end
  end

endmodule

bind dec4_alu dec4_alu_chk #(.DIGITS(DIGITS)) i_chk (
  .opA      (opA),
  .opSel    (opSel),
  .result   (result),
  .zeroFlag (zeroFlag),
  .negFlag  (negFlag),
  .ovfFlag  (ovfFlag),
  .badDigit (badDigit)
);

// File: tb/test_dec4_alu.sv
module test_dec4_alu;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] opA = '0, opB = '0, result;
  logic [2:0]  opSel = '0, condSel = '0;
  logic        zeroFlag, negFlag, ovfFlag, badDigit, condMet;
  int          checks = 0, failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dec4_alu i_dec4_alu (
    .opA(opA), .opB(opB), .opSel(opSel), .condSel(condSel),
    .result(result), .zeroFlag(zeroFlag), .negFlag(negFlag),
    .ovfFlag(ovfFlag), .badDigit(badDigit), .condMet(condMet)
  );

  function automatic int uval(logic [15:0] w);
    return int'(w[15:12]) * 1000 + int'(w[11:8]) * 100 + int'(w[7:4]) * 10 + int'(w[3:0]);
  endfunction

  function automatic int sval(int u);
    return (u >= 5000) ? u - 10000 : u;
  endfunction

  function automatic logic [15:0] toBcd(int v);
    int m;
    m = ((v % 10000) + 10000) % 10000;
    return {4'(m / 1000), 4'((m / 100) % 10), 4'((m / 10) % 10), 4'(m % 10)};
  endfunction

  task automatic chk(string req, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic apply(logic [15:0] a, logic [15:0] b, logic [2:0] op, logic [2:0] cnd);
    @(negedge clk);
    opA = a; opB = b; opSel = op; condSel = cnd;
    #(CLK_PERIOD/4);
  endtask

  // Drive one operation on decimal operands and check it against the integer model
  task automatic runOp(string req, logic [15:0] a, logic [15:0] b, logic [2:0] op);
    int ua, ub, ex;
    logic [15:0] er;
    logic eo;
    ua = uval(a); ub = uval(b); eo = 1'b0;
    case (op)
      3'd0: er = 16'h0000;
      3'd1: er = toBcd(ua + 1);
      3'd2: er = toBcd(ua - 1);
      3'd3: er = toBcd(-ua);
      3'd4: er = toBcd(ua * 10);
      3'd5: er = toBcd(ua / 10);
      3'd6: begin ex = sval(ua) + sval(ub); er = toBcd(ex); eo = (ex > 4999) || (ex < -5000); end
      default: begin ex = sval(ua) - sval(ub); er = toBcd(ex); eo = (ex > 4999) || (ex < -5000); end
    endcase
    apply(a, b, op, 3'd6);
    chk(req, "result", result, er);
    chk("R8", "ovfFlag", {15'b0, ovfFlag}, {15'b0, eo});
    chk("R9", "zeroFlag", {15'b0, zeroFlag}, {15'b0, er == 16'h0});
    chk("R9", "negFlag", {15'b0, negFlag}, {15'b0, er[15:12] >= 4'd5});
    chk("R11", "badDigit", {15'b0, badDigit}, 16'h0);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    apply(16'h0000, 16'h0000, 3'd0, 3'd0);
    chk("R1", "reset result", result, 16'h0000);
    chk("R1", "reset zeroFlag", {15'b0, zeroFlag}, 16'h1);
    chk("R10", "reset condMet EQ", {15'b0, condMet}, 16'h1);
    rst = 1'b0;
  endtask

  task automatic t_clear();
    runOp("R1", 16'h9876, 16'h1234, 3'd0);
    runOp("R1", 16'h4999, 16'h0000, 3'd0);
  endtask

  task automatic t_incdec();
    runOp("R2", 16'h9999, 16'h0000, 3'd1);
    chk("R2", "9999+1 literal", result, 16'h0000);
    runOp("R2", 16'h0099, 16'h0000, 3'd1);
    chk("R2", "0099+1 literal", result, 16'h0100);
    runOp("R2", 16'h4999, 16'h0000, 3'd1);
    runOp("R2", 16'h0000, 16'h0000, 3'd2);
    chk("R2", "0000-1 literal", result, 16'h9999);
    runOp("R2", 16'h1000, 16'h0000, 3'd2);
  endtask

  task automatic t_negate();
    runOp("R3", 16'h0000, 16'h0000, 3'd3);
    runOp("R3", 16'h5000, 16'h0000, 3'd3);
    chk("R3", "neg 5000 literal", result, 16'h5000);
    runOp("R3", 16'h0001, 16'h0000, 3'd3);
    chk("R3", "neg 0001 literal", result, 16'h9999);
    runOp("R3", 16'h1230, 16'h0000, 3'd3);
  endtask

  task automatic t_shifts();
    runOp("R4", 16'h9876, 16'h0000, 3'd4);
    chk("R4", "shl literal", result, 16'h8760);
    runOp("R4", 16'h0123, 16'h0000, 3'd4);
    runOp("R5", 16'h9876, 16'h0000, 3'd5);
    chk("R5", "shr negative literal", result, 16'h0987);
    runOp("R5", 16'h0009, 16'h0000, 3'd5);
  endtask

  task automatic t_add();
    runOp("R6", 16'h1234, 16'h2345, 3'd6);
    runOp("R6", 16'h0005, 16'h0005, 3'd6);
    chk("R6", "digit carry literal", result, 16'h0010);
    runOp("R6", 16'h0001, 16'h9999, 3'd6);
    runOp("R6", 16'h4999, 16'h0001, 3'd6);
    chk("R8", "4999+1 overflow", {15'b0, ovfFlag}, 16'h1);
    runOp("R6", 16'h5000, 16'h9999, 3'd6);
    runOp("R6", 16'h9999, 16'h9999, 3'd6);
    runOp("R6", 16'h0478, 16'h0396, 3'd6);
  endtask

  task automatic t_sub();
    runOp("R7", 16'h2345, 16'h1234, 3'd7);
    runOp("R7", 16'h0000, 16'h0001, 3'd7);
    runOp("R7", 16'h0000, 16'h5000, 3'd7);
    chk("R8", "0-(-5000) overflow", {15'b0, ovfFlag}, 16'h1);
    runOp("R7", 16'h9999, 16'h5000, 3'd7);
    runOp("R7", 16'h5000, 16'h0001, 3'd7);
    runOp("R7", 16'h4321, 16'h0000, 3'd7);
  endtask

  task automatic t_cond();
    logic [15:0] vals [5] = '{16'h0000, 16'h0001, 16'h4999, 16'h5000, 16'h9999};
    for (int v = 0; v < 5; v++) begin
      for (int c = 0; c < 8; c++) begin
        int s;
        logic e;
        s = sval(uval(vals[v]));
        case (c)
          0: e = (s == 0);
          1: e = (s != 0);
          2: e = (s > 0);
          3: e = (s >= 0);
          4: e = (s < 0);
          5: e = (s <= 0);
          6: e = 1'b1;
          default: e = 1'b0;
        endcase
        apply(vals[v], 16'h0000, 3'd1, 3'(c));
        chk("R10", $sformatf("condMet A=%h cond=%0d", vals[v], c), {15'b0, condMet}, {15'b0, e});
      end
    end
  endtask

  task automatic t_invalid();
    apply(16'h00A0, 16'h0000, 3'd1, 3'd6);
    chk("R11", "bad A inc flag", {15'b0, badDigit}, 16'h1);
    chk("R11", "bad A inc result", result, 16'h0000);
    chk("R11", "bad A condMet", {15'b0, condMet}, 16'h0);
    apply(16'h4999, 16'h000F, 3'd6, 3'd6);
    chk("R11", "bad B add flag", {15'b0, badDigit}, 16'h1);
    chk("R11", "bad B add result", result, 16'h0000);
    chk("R11", "bad B add ovf", {15'b0, ovfFlag}, 16'h0);
    apply(16'h0123, 16'hFFFF, 3'd4, 3'd6);
    chk("R11", "unused B shl flag", {15'b0, badDigit}, 16'h0);
    chk("R11", "unused B shl result", result, 16'h1230);
    apply(16'hFFFF, 16'hFFFF, 3'd0, 3'd6);
    chk("R1", "clear ignores bad digits", {15'b0, badDigit}, 16'h0);
    chk("R1", "clear result bad ops", result, 16'h0000);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_clear();
    t_incdec();
    t_negate();
    t_shifts();
    t_add();
    t_sub();
    t_cond();
    t_invalid();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule